// File: doc/BRIEF.md
# Prime-Length DCT Index Permutation Pre-Adder

This block prepares an 11-point forward DCT for evaluation by two 5-point convolvers, one cyclic and one skew-cyclic. It collects a block of eleven signed 8-bit samples over a valid/ready stream. It then reorders them in two steps. The first step is a modular reflection of the index. The second step is a walk through the powers of the primitive root 2 modulo 11. The walk pairs each reordered position with its negative modulo 11. From each pair the block forms a sum, which feeds the cyclic convolver, and a difference, which feeds the skew-cyclic convolver. It also forms the DC coefficient by adding the centre sample to the five pair sums. No multiplier is used.

The block works on one block at a time. It accepts samples while it is filling. It then spends five cycles on the pairs, with one pair per cycle, during which the input is stalled. After that it pulses a done strobe. All outputs hold their values until the pair phase of the next block begins.

Top module: `dct11_preadd`

## Requirements
- R1: `in_ready` is high while the block is filling. It drops in the cycle after the eleventh sample is accepted and stays low for exactly 5 cycles (the pair phase).
- R2: Accepted samples are numbered y0..y10 in arrival order. A sample with `in_valid` high while `in_ready` is low is ignored and leaves every output unchanged.
- R3: Pair sums are 9-bit signed. Slot s occupies `sum_o[9s+8:9s]`, and slots 0..4 hold y3+y7, y1+y9, y8+y2, y0+y10 and y6+y4.
- R4: Pair differences are 9-bit signed and use the same slot layout in `diff_o`. They hold y3-y7, y1-y9, y8-y2, y0-y10 and y6-y4.
- R5: `dc_o` is the 12-bit signed sum of all eleven samples. Extreme inputs (all -128, or all +127) do not overflow it.
- R6: `done_o` is high for exactly one cycle, in the cycle after the last pair cycle. A new block may start in that same cycle.
- R7: After reset `in_ready` is high, `done_o` is low and all outputs are zero.
- R8: Outputs change only during a pair phase. Between phases they hold the results of the last completed block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block is filling and accepts the sample |
| in_data | input | 8 | Signed input sample |
| done_o | output | 1 | One-cycle strobe: results complete |
| sum_o | output | 45 | Five 9-bit signed pair sums (cyclic convolver input) |
| diff_o | output | 45 | Five 9-bit signed pair differences (skew-cyclic input) |
| dc_o | output | 12 | Signed DC coefficient (sum of all samples) |

## Verification
The assertions check the framing on every cycle:
- the ready drop after the last sample,
- the single-cycle done that follows a pair cycle,
- the output holding outside the pair phase.

The arithmetic itself can only be shown by the bench's scenarios, which compare each pair slot and the DC word against a behavioural model. Those scenarios cover ramps, extreme values, alternating signs, pseudo-random blocks, gaps in the input and back-to-back blocks. The bench also drives junk with `in_valid` high while the block is busy, to show that such samples are dropped.

// File: rtl/dct11_pkg.sv
package dct11_pkg;
  localparam int PLEN  = 11;
  localparam int HALF  = (PLEN - 1) / 2;
  localparam int ROOT  = 2;
  localparam int CNT_W = $clog2(PLEN);

  // modular reflection: slot i -> sample index
  function automatic int reflect_idx(input int i, input int p);
    int h;
    h = (p - 1) / 2;
    return (i <= h) ? (h - i) : (p + h - i);
  endfunction

  // root^e mod p
  function automatic int root_pow(input int e, input int g, input int p);
    int r;
    r = 1;
    for (int j = 0; j < e; j++) r = (r * g) % p;
    return r;
  endfunction

  function automatic logic signed [8:0] pair_add(input logic [7:0] a, input logic [7:0] b);
    return $signed({a[7], a}) + $signed({b[7], b});
  endfunction

  function automatic logic signed [8:0] pair_sub(input logic [7:0] a, input logic [7:0] b);
    return $signed({a[7], a}) - $signed({b[7], b});
  endfunction
endpackage

// File: rtl/dct11_sample_buf.sv
module dct11_sample_buf #(
  parameter int W  = 8,
  parameter int AW = 4,
  parameter int CENTER = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [W-1:0]  rd_data_a,
  output logic [W-1:0]  rd_data_b,
  output logic [W-1:0]  rd_center
);
  localparam int SLOTS = 2 ** AW;
  logic [W-1:0] mem [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data_a = mem[rd_addr_a];
  assign rd_data_b = mem[rd_addr_b];
  assign rd_center = mem[CENTER];
endmodule

// File: rtl/dct11_pair_addr.sv
module dct11_pair_addr
  import dct11_pkg::*;
#(
  parameter int P  = PLEN,
  parameter int G  = ROOT,
  parameter int AW = CNT_W
) (
  input  logic [AW-1:0] idx,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b
);
  localparam int H = (P - 1) / 2;
  localparam int ENTRIES = 2 ** AW;
  logic [AW-1:0] tab_a [ENTRIES];
  logic [AW-1:0] tab_b [ENTRIES];

  // pair s: reordered positions g^(s+1) and its negative mod P
  for (genvar s = 0; s < ENTRIES; s++) begin : g_tab
    if (s < H) begin : g_used
      localparam int POS = root_pow(s + 1, G, P);
      assign tab_a[s] = AW'(reflect_idx(POS, P));
      assign tab_b[s] = AW'(reflect_idx(P - POS, P));
    end else begin : g_unused
      assign tab_a[s] = '0;
      assign tab_b[s] = '0;
    end
  end

  assign addr_a = tab_a[idx];
  assign addr_b = tab_b[idx];
endmodule

// File: rtl/dct11_pair_alu.sv
module dct11_pair_alu
  import dct11_pkg::*;
#(
  parameter int W    = 8,
  parameter int WDC  = 12
) (
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  logic [W-1:0]         center,
  input  logic                 first,
  input  logic signed [WDC-1:0] acc_in,
  output logic signed [W:0]    sum,
  output logic signed [W:0]    diff,
  output logic signed [WDC-1:0] acc_out
);
  logic signed [WDC-1:0] base;

  assign sum  = pair_add(a, b);
  assign diff = pair_sub(a, b);
  assign base = first ? WDC'($signed(center)) : acc_in;
  assign acc_out = base + WDC'(sum);
endmodule

// File: rtl/dct11_preadd.sv
module dct11_preadd
  import dct11_pkg::*;
#(
  parameter int W_IN = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [W_IN-1:0]         in_data,
  output logic                    done_o,
  output logic [HALF*(W_IN+1)-1:0] sum_o,
  output logic [HALF*(W_IN+1)-1:0] diff_o,
  output logic [W_IN+CNT_W-1:0]   dc_o
);
  localparam int WP  = W_IN + 1;
  localparam int WDC = W_IN + CNT_W;

  typedef enum logic {ST_FILL, ST_PAIR} st_e;
  st_e state;
  logic [CNT_W-1:0] cnt;
  logic done_q;
  logic signed [WP-1:0]  sum_q  [HALF];
  logic signed [WP-1:0]  diff_q [HALF];
  logic signed [WDC-1:0] dc_q;

  // named internal events
  logic beat_accept, beat_last, pair_step, pair_last;
  assign in_ready    = (state == ST_FILL);
  assign beat_accept = in_valid && in_ready;
  assign beat_last   = beat_accept && (cnt == CNT_W'(PLEN - 1));
  assign pair_step   = (state == ST_PAIR);
  assign pair_last   = pair_step && (cnt == CNT_W'(HALF - 1));

  logic [CNT_W-1:0] addr_a, addr_b;
  logic [W_IN-1:0]  smp_a, smp_b, smp_c;
  logic signed [WP-1:0]  p_sum, p_diff;
  logic signed [WDC-1:0] acc_nx;

  dct11_pair_addr #(.P(PLEN), .G(ROOT), .AW(CNT_W)) u_addr (
    .idx(cnt), .addr_a(addr_a), .addr_b(addr_b)
  );

  dct11_sample_buf #(.W(W_IN), .AW(CNT_W), .CENTER(HALF)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(beat_accept), .wr_addr(cnt), .wr_data(in_data),
    .rd_addr_a(addr_a), .rd_addr_b(addr_b),
    .rd_data_a(smp_a), .rd_data_b(smp_b), .rd_center(smp_c)
  );

  dct11_pair_alu #(.W(W_IN), .WDC(WDC)) u_alu (
    .a(smp_a), .b(smp_b), .center(smp_c), .first(cnt == '0),
    .acc_in(dc_q), .sum(p_sum), .diff(p_diff), .acc_out(acc_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_FILL;
      cnt    <= '0;
      done_q <= 1'b0;
      dc_q   <= '0;
      for (int s = 0; s < HALF; s++) begin
        sum_q[s]  <= '0;
        diff_q[s] <= '0;
      end
    end else begin
      done_q <= pair_last;
      if (pair_step) begin
        sum_q[cnt]  <= p_sum;
        diff_q[cnt] <= p_diff;
        dc_q        <= acc_nx;
        if (pair_last) begin
          state <= ST_FILL;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (beat_accept) begin
        if (beat_last) begin
          state <= ST_PAIR;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  for (genvar s = 0; s < HALF; s++) begin : g_out
    assign sum_o[s*WP +: WP]  = sum_q[s];
    assign diff_o[s*WP +: WP] = diff_q[s];
  end
  assign dc_o   = dc_q;
  assign done_o = done_q;
endmodule

// File: rtl/dct11_preadd_chk.sv
module dct11_preadd_chk #(
  parameter int WS  = 45,
  parameter int WDC = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic           done_o,
  input logic [WS-1:0]  sum_o,
  input logic [WDC-1:0] dc_o,
  input logic           beat_last,
  input logic           pair_step
);
  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> (!in_ready && pair_step));

  assert_busy_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pair_step |-> !in_ready);

  assert_done_after_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(pair_step));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_hold_dc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_step |=> $stable(dc_o));

  assert_hold_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_step |=> $stable(sum_o));
endmodule

bind dct11_preadd dct11_preadd_chk #(.WS(45), .WDC(12)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .done_o(done_o),
  .sum_o(sum_o), .dc_o(dc_o), .beat_last(beat_last), .pair_step(pair_step)
);

// File: tb/dct11_preadd_bench.sv
module dct11_preadd_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, done_o;
  logic [44:0] sum_o, diff_o;
  logic [11:0] dc_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dct11_preadd u_dct11_preadd (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .done_o(done_o), .sum_o(sum_o), .diff_o(diff_o), .dc_o(dc_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // behavioural model
  int m_buf [11];
  int m_cnt = 0, m_busy = 0, m_done = 0;
  int e_sum [5], e_diff [5], e_dc = 0;
  int lcg = 12345;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic void make_expect();
    int p;
    p = 1;
    e_dc = 0;
    for (int i = 0; i < 11; i++) e_dc += m_buf[i];
    for (int s = 0; s < 5; s++) begin
      p = (p * 2) % 11;
      e_sum[s]  = m_buf[(16 - p) % 11] + m_buf[(p + 5) % 11];
      e_diff[s] = m_buf[(16 - p) % 11] - m_buf[(p + 5) % 11];
    end
  endfunction

  // compare at negedge, then drive inputs, then advance model
  task automatic step(input bit v, input int d);
    bit exp_rdy;
    exp_rdy = (m_busy == 0);
    chk(in_ready == exp_rdy, "R1 in_ready", int'(in_ready), int'(exp_rdy));
    chk(done_o == m_done[0], "R6 done_o", int'(done_o), m_done);
    if (m_busy == 0) begin
      for (int s = 0; s < 5; s++) begin
        chk($signed(sum_o[9*s +: 9]) == e_sum[s], "R3/R8 pair sum",
            int'($signed(sum_o[9*s +: 9])), e_sum[s]);
        chk($signed(diff_o[9*s +: 9]) == e_diff[s], "R4/R8 pair diff",
            int'($signed(diff_o[9*s +: 9])), e_diff[s]);
      end
      chk($signed(dc_o) == e_dc, "R5/R8 dc", int'($signed(dc_o)), e_dc);
    end
    in_valid = v;
    in_data  = 8'(d);
    m_done = (m_busy == 1) ? 1 : 0;
    if (m_busy > 0) begin
      m_busy--;
    end else if (v) begin
      m_buf[m_cnt] = d;
      m_cnt++;
      if (m_cnt == 11) begin
        m_cnt = 0;
        m_busy = 5;
        make_expect();
      end
    end
    @(negedge clk);
  endtask

  // R2: junk offered while busy must be dropped
  task automatic send_block(input int vals [11], input int gap);
    for (int i = 0; i < 11; i++) begin
      for (int g = 0; g < gap; g++) step(0, 0);
      step(1, vals[i]);
    end
    while (m_busy > 0) step(1, 8'h5a);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int blk [11];
    for (int s = 0; s < 5; s++) begin e_sum[s] = 0; e_diff[s] = 0; end
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(in_ready == 1'b1, "R7 ready after reset", int'(in_ready), 1);
    chk(done_o == 1'b0, "R7 done after reset", int'(done_o), 0);
    chk(sum_o == '0 && diff_o == '0 && dc_o == '0, "R7 outputs zero", int'(dc_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0);
    // ramp, R3 R4 R5
    for (int i = 0; i < 11; i++) blk[i] = i * 10 - 50;
    send_block(blk, 0);
    repeat (3) step(0, 0);
    // extremes R5
    for (int i = 0; i < 11; i++) blk[i] = -128;
    send_block(blk, 1);
    for (int i = 0; i < 11; i++) blk[i] = 127;
    send_block(blk, 0);          // back-to-back R6
    // alternating signs
    for (int i = 0; i < 11; i++) blk[i] = (i % 2) ? -128 : 127;
    send_block(blk, 2);
    repeat (2) step(0, 0);
    // single nonzero sample per position: index mapping R3 R4
    for (int j = 0; j < 11; j++) begin
      for (int i = 0; i < 11; i++) blk[i] = (i == j) ? (j + 1) : 0;
      send_block(blk, j % 2);
    end
    // pseudo-random
    for (int r = 0; r < 20; r++) begin
      for (int i = 0; i < 11; i++) begin
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        blk[i] = ((lcg >> 8) & 255) - 128;
      end
      send_block(blk, r % 3);
    end
    repeat (4) step(1, 8'h33); // R2 junk only counts as samples when ready
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule